// File: doc/BRIEF.md
# SKP-Based Elastic Rate Match Buffer

This block is the receive-side elastic store of a Gen3 serial link. It carries 32-bit words, each four 8-bit symbols, from the recovered write clock into the local read clock. The two clocks may differ by up to ±300 ppm. Occupancy is held in a safe band by adjusting whole SKP words, four SKP symbols each. When the buffer runs too full, one SKP word of an incoming SKP ordered set is dropped before it is stored. When it runs too empty, one extra SKP word is handed out ahead of the next SKP ordered set that reaches the read port.

Upstream logic marks every word that belongs to a SKP ordered set with a flag, and marks the word that closes the set with a second flag. The read side presents words one cycle after each read request. Alongside each word it gives a 3-bit status code for insertion, removal, overflow and underflow. After a full or empty condition the buffer keeps running.

Top module: `skp_rate_match`

## Requirements
- R1: Words written with `wr_valid` come out on the read port in write order, with their `skp` and `last` flags kept. `rd_valid` is high only in the read cycle after a cycle with `rd_en` high and stored data available.
- R2: While reset is asserted and after its release, before any read, `rd_valid` is 0 and `rd_status` is 000 (normal).
- R3: If the write side sees an occupancy of at least `AF_LEVEL` (12) when a word arrives that has `wr_skp` high and `wr_last` low, that word is dropped and not stored. A word with `wr_last` high is never dropped this way.
- R4: When a SKP word has been dropped, the next stored word of the same ordered set is delivered with `rd_status` 010 (SKP removed).
- R5: A read may find that the first stored word of a SKP ordered set is at the head and that read-side occupancy is at most `AE_LEVEL` (4). That read returns an inserted word instead: data 0xAAAAAAAA, `rd_skp` 1, `rd_last` 0 and `rd_status` 001 (SKP added). The head word is not consumed and comes out on the next read.
- R6: At most one adjustment is made per SKP ordered set. A second SKP word of a set that already lost one is stored. A set that lost a word gets no insertion. Two insertions never come one after the other.
- R7: A read request while the buffer is empty yields `rd_valid` 0 and `rd_status` 110 (underflow). Operation then continues normally.
- R8: A write while 16 words (`DEPTH`) are held is dropped. The read side reports `rd_status` 101 (overflow) for exactly one read-clock cycle, whether or not `rd_en` is high.
- R9: Suppose the write clock runs about 0.25% faster than the read clock, with continuous reads and a SKP ordered set every eight words. Then all non-SKP words arrive in order with none lost, no overflow or underflow is reported, and at least one SKP removal takes place.
- R10: In every other cycle `rd_status` is 000. When events coincide, underflow outranks overflow, and overflow outranks added or removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write (recovered) clock |
| rclk | input | 1 | Read (local) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside each domain through a synchronizer |
| wr_valid | input | 1 | A word is offered on the write side |
| wr_data | input | 32 | Four symbols of the offered word |
| wr_skp | input | 1 | Word belongs to a SKP ordered set |
| wr_last | input | 1 | Word closes the SKP ordered set |
| rd_en | input | 1 | Read request |
| rd_valid | output | 1 | Read port holds a delivered word |
| rd_data | output | 32 | Delivered word |
| rd_skp | output | 1 | Delivered word is a SKP-set word |
| rd_last | output | 1 | Delivered word closes its SKP ordered set |
| rd_status | output | 3 | 000 normal, 001 added, 010 removed, 101 overflow, 110 underflow |

## Verification
The bench builds the block with its default parameters: 16 words deep, remove threshold 12 and insert threshold 4. With these values, a dozen data words raise the write-side fill past the removal point, a short ordered set reaches the insert point after two reads, and seventeen writes force an overflow. Each adjustment path and each full or empty path is therefore reached in a few tens of cycles. A final streaming run with a read clock about 0.25% slow lets the fill drift upward on its own. This exercises removals that happen without being forced.

// File: rtl/rmf_pkg.sv
`timescale 1ns/1ps
package rmf_pkg;
  localparam int SYM_W     = 8;
  localparam int WORD_SYMS = 4;
  localparam int WORD_W    = SYM_W * WORD_SYMS;
  localparam logic [SYM_W-1:0]  SKP_SYM  = 8'hAA;
  localparam logic [WORD_W-1:0] SKP_WORD = {WORD_SYMS{SKP_SYM}};

  typedef enum logic [2:0] {
    ST_NORM = 3'b000,
    ST_ADD  = 3'b001,
    ST_REM  = 3'b010,
    ST_OVF  = 3'b101,
    ST_UNF  = 3'b110
  } rmf_status_e;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              skp;
    logic              last;
    logic              start;  // first stored word of a SKP ordered set
    logic              del;    // a SKP word of this set was dropped
  } rmf_entry_t;
endpackage

// File: rtl/rmf_sync.sv
`timescale 1ns/1ps
module rmf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/rmf_rst_sync.sv
`timescale 1ns/1ps
module rmf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      rst_n_o <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_n_o <= stage_q;
    end
  end
endmodule

// File: rtl/rmf_wr_ctrl.sv
`timescale 1ns/1ps
module rmf_wr_ctrl
  import rmf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int AF_LEVEL = 12,
  parameter int AW       = 4,
  parameter int PW       = 5
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_skp,
  input  logic              wr_last,
  input  logic [PW-1:0]     rgray_s,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output rmf_entry_t        mem_wentry,
  output logic [PW-1:0]     wgray,
  output logic              ovf_tgl
);
  logic [PW-1:0] wbin_q, wbin_d, wgray_d, rbin_s, wocc;
  logic          full, del_hit;
  logic          del_done_q, del_done_d;   // one removal per ordered set
  logic          pend_del_q, pend_del_d;   // tag the next stored word
  logic          stored_q, stored_d;       // a word of the current set is stored
  logic          ovf_d;

  always_comb begin
    rbin_s[PW-1] = rgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
  end

  assign wocc    = wbin_q - rbin_s;
  assign full    = (wocc == PW'(DEPTH));
  assign del_hit = wr_valid & ~full & wr_skp & ~wr_last & ~del_done_q
                   & (wocc >= PW'(AF_LEVEL));
  assign mem_we  = wr_valid & ~full & ~del_hit;
  assign mem_waddr = wbin_q[AW-1:0];

  always_comb begin
    mem_wentry.data  = wr_data;
    mem_wentry.skp   = wr_skp;
    mem_wentry.last  = wr_last;
    mem_wentry.start = wr_skp & ~stored_q;
    mem_wentry.del   = wr_skp & pend_del_q;
  end

  always_comb begin
    wbin_d     = wbin_q;
    del_done_d = del_done_q;
    pend_del_d = pend_del_q;
    stored_d   = stored_q;
    ovf_d      = ovf_tgl;
    if (mem_we) begin
      wbin_d     = wbin_q + 1'b1;
      pend_del_d = 1'b0;
      if (wr_skp && wr_last) begin
        stored_d   = 1'b0;
        del_done_d = 1'b0;
      end else if (wr_skp) begin
        stored_d = 1'b1;
      end
    end
    if (del_hit) begin
      del_done_d = 1'b1;
      pend_del_d = 1'b1;
    end
    if (wr_valid && full) ovf_d = ~ovf_tgl;
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q     <= '0;
      wgray      <= '0;
      del_done_q <= 1'b0;
      pend_del_q <= 1'b0;
      stored_q   <= 1'b0;
      ovf_tgl    <= 1'b0;
    end else begin
      wbin_q     <= wbin_d;
      wgray      <= wgray_d;
      del_done_q <= del_done_d;
      pend_del_q <= pend_del_d;
      stored_q   <= stored_d;
      ovf_tgl    <= ovf_d;
    end
  end
endmodule

// File: rtl/rmf_rd_ctrl.sv
`timescale 1ns/1ps
module rmf_rd_ctrl
  import rmf_pkg::*;
#(
  parameter int AE_LEVEL = 4,
  parameter int AW       = 4,
  parameter int PW       = 5
) (
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  input  logic [PW-1:0]     wgray_s,
  input  logic              ovf_s,
  input  rmf_entry_t        head,
  output logic [AW-1:0]     raddr,
  output logic [PW-1:0]     rgray,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_skp,
  output logic              rd_last,
  output logic [2:0]        rd_status
);
  logic [PW-1:0]     rbin_q, rbin_d, rgray_d, wbin_s, rocc;
  logic              empty, ins_hit, ovf_evt;
  logic              ins_done_q, ins_done_d, ovf_prev_q;
  logic              valid_d, skp_d, last_d, out_en;
  logic [WORD_W-1:0] data_d;
  rmf_status_e       st_q, st_d;

  always_comb begin
    wbin_s[PW-1] = wgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
  end

  assign rocc    = wbin_s - rbin_q;
  assign empty   = (rocc == '0);
  assign ins_hit = ~empty & head.start & ~head.del & ~ins_done_q
                   & (rocc <= PW'(AE_LEVEL));
  assign ovf_evt = ovf_s ^ ovf_prev_q;
  assign raddr   = rbin_q[AW-1:0];

  always_comb begin
    rbin_d     = rbin_q;
    ins_done_d = ins_done_q;
    valid_d    = 1'b0;
    out_en     = 1'b0;
    data_d     = head.data;
    skp_d      = head.skp;
    last_d     = head.last;
    st_d       = ST_NORM;
    if (rd_en) begin
      if (empty) begin
        st_d = ST_UNF;
      end else if (ins_hit) begin
        valid_d    = 1'b1;
        out_en     = 1'b1;
        data_d     = SKP_WORD;
        skp_d      = 1'b1;
        last_d     = 1'b0;
        st_d       = ST_ADD;
        ins_done_d = 1'b1;
      end else begin
        valid_d    = 1'b1;
        out_en     = 1'b1;
        st_d       = head.del ? ST_REM : ST_NORM;
        ins_done_d = 1'b0;
        rbin_d     = rbin_q + 1'b1;
      end
    end
    if (ovf_evt && st_d != ST_UNF) st_d = ST_OVF;
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q     <= '0;
      rgray      <= '0;
      ins_done_q <= 1'b0;
      ovf_prev_q <= 1'b0;
      rd_valid   <= 1'b0;
      st_q       <= ST_NORM;
    end else begin
      rbin_q     <= rbin_d;
      rgray      <= rgray_d;
      ins_done_q <= ins_done_d;
      ovf_prev_q <= ovf_s;
      rd_valid   <= valid_d;
      st_q       <= st_d;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rd_data <= '0;
      rd_skp  <= 1'b0;
      rd_last <= 1'b0;
    end else if (out_en) begin
      rd_data <= data_d;
      rd_skp  <= skp_d;
      rd_last <= last_d;
    end
  end

  assign rd_status = st_q;
endmodule

// File: rtl/skp_rate_match.sv
`timescale 1ns/1ps
module skp_rate_match
  import rmf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int AF_LEVEL = 12,
  parameter int AE_LEVEL = 4
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_skp,
  input  logic              wr_last,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_skp,
  output logic              rd_last,
  output logic [2:0]        rd_status
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          wrst_n, rrst_n;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic          ovf_tgl, ovf_s, mem_we;
  logic [AW-1:0] mem_waddr, raddr;
  rmf_entry_t    mem_wentry, head;
  rmf_entry_t    mem [DEPTH];

  rmf_rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .rst_n_o(wrst_n));
  rmf_rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .rst_n_o(rrst_n));

  rmf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  rmf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
  rmf_sync #(.W(1))  u_ovf (.clk(rclk), .rst_n(rrst_n), .d(ovf_tgl), .q(ovf_s));

  rmf_wr_ctrl #(.DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL), .AW(AW), .PW(PW)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_skp(wr_skp), .wr_last(wr_last), .rgray_s(rgray_s), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wentry(mem_wentry), .wgray(wgray),
    .ovf_tgl(ovf_tgl)
  );

  always_ff @(posedge wclk) begin
    if (mem_we) mem[mem_waddr] <= mem_wentry;
  end
  assign head = mem[raddr];

  rmf_rd_ctrl #(.AE_LEVEL(AE_LEVEL), .AW(AW), .PW(PW)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .wgray_s(wgray_s),
    .ovf_s(ovf_s), .head(head), .raddr(raddr), .rgray(rgray),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_skp(rd_skp),
    .rd_last(rd_last), .rd_status(rd_status)
  );
endmodule

// File: rtl/rmf_checker.sv
`timescale 1ns/1ps
module rmf_checker (
  input logic        rclk,
  input logic        rrst_n,
  input logic        rd_en,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic        rd_skp,
  input logic        rd_last,
  input logic [2:0]  rd_status
);
  // R1: a delivered word always follows a read request
  a_r1_valid_after_req: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rd_en |=> !rd_valid);

  // R5: an added word is a plain SKP word
  a_r5_added_word: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_status == 3'b001) |-> (rd_valid && rd_skp && !rd_last
                               && rd_data == 32'hAAAA_AAAA));

  // R4: a removal is reported on a delivered SKP-set word
  a_r4_removed_on_skp: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_status == 3'b010) |-> (rd_valid && rd_skp));

  // R6: never two additions in a row
  a_r6_single_add: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_status == 3'b001) |=> (rd_status != 3'b001));

  // R7: underflow delivers nothing
  a_r7_underflow_invalid: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_status == 3'b110) |-> !rd_valid);

  // R10: only defined codes appear
  a_r10_legal_code: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_status inside {3'b000, 3'b001, 3'b010, 3'b101, 3'b110});
endmodule

bind skp_rate_match rmf_checker u_chk (
  .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .rd_data(rd_data), .rd_skp(rd_skp), .rd_last(rd_last), .rd_status(rd_status)
);

// File: tb/skp_rate_match_test.sv
`timescale 1ns/1ps
module skp_rate_match_test;
  localparam logic [31:0] SKPW = 32'hAAAA_AAAA;
  localparam logic [31:0] ENDW = 32'hE100_005A;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_skp = 1'b0, wr_last = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic rd_valid, rd_skp, rd_last;
  logic [31:0] rd_data;
  logic [2:0]  rd_status;
  realtime rhalf = 4.0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  skp_rate_match uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_skp(wr_skp), .wr_last(wr_last), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_skp(rd_skp),
    .rd_last(rd_last), .rd_status(rd_status)
  );

  always #4 wclk = ~wclk;
  initial begin
    #1.3;
    forever #(rhalf) rclk = ~rclk;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(logic [31:0] d, logic s, logic l);
    wr_valid = 1'b1; wr_data = d; wr_skp = s; wr_last = l;
    @(negedge wclk);
    wr_valid = 1'b0; wr_skp = 1'b0; wr_last = 1'b0;
  endtask

  // one read; compares {valid, skp, last, status, data}
  task automatic rd_expect(string req, logic v, logic [31:0] d, logic s,
                           logic l, logic [2:0] st);
    rd_en = 1'b1;
    @(negedge rclk);
    if (v) check(req, {rd_valid, rd_skp, rd_last, rd_status, rd_data},
                      {v, s, l, st, d});
    else   check(req, {rd_valid, rd_status}, {v, st});
  endtask

  task automatic settle();
    rd_en = 1'b0;
    repeat (8) @(negedge wclk);
    repeat (8) @(negedge rclk);
    @(negedge wclk);
  endtask

  task automatic t_reset();
    check("R2 valid in reset", rd_valid, 0);
    check("R2 status in reset", rd_status, 3'b000);
    @(negedge wclk); rst_n = 1'b1;
    settle();
    check("R2 valid after reset", rd_valid, 0);
    check("R2 status after reset", rd_status, 3'b000);
  endtask

  task automatic t_pass();
    for (int i = 0; i < 5; i++) wr_word(32'h0100_0000 + i, 1'b0, 1'b0);
    settle();
    @(negedge rclk);
    for (int i = 0; i < 5; i++)
      rd_expect("R1 in-order data", 1'b1, 32'h0100_0000 + i, 1'b0, 1'b0, 3'b000);
    rd_expect("R7 underflow", 1'b0, '0, 1'b0, 1'b0, 3'b110);
    rd_en = 1'b0;
    @(negedge rclk);
    check("R1 no valid without request", rd_valid, 0);
    check("R10 normal after underflow", rd_status, 3'b000);
    settle();
  endtask

  task automatic t_delete();
    for (int i = 0; i < 12; i++) wr_word(32'h0200_0000 + i, 1'b0, 1'b0);
    wr_word(SKPW, 1'b1, 1'b0);   // dropped (R3)
    wr_word(SKPW, 1'b1, 1'b0);   // kept, tagged (R6: second one stays)
    wr_word(SKPW, 1'b1, 1'b0);
    wr_word(ENDW, 1'b1, 1'b1);
    settle();
    @(negedge rclk);
    for (int i = 0; i < 12; i++)
      rd_expect("R3 data before set", 1'b1, 32'h0200_0000 + i, 1'b0, 1'b0, 3'b000);
    // near-empty here, but a set with a removal gets no insertion (R6)
    rd_expect("R4 removed code", 1'b1, SKPW, 1'b1, 1'b0, 3'b010);
    rd_expect("R6 second SKP kept", 1'b1, SKPW, 1'b1, 1'b0, 3'b000);
    rd_expect("R3 end word kept", 1'b1, ENDW, 1'b1, 1'b1, 3'b000);
    rd_expect("R3 only one dropped", 1'b0, '0, 1'b0, 1'b0, 3'b110);
    settle();
  endtask

  task automatic t_insert();
    wr_word(32'h0300_0000, 1'b0, 1'b0);
    wr_word(32'h0300_0001, 1'b0, 1'b0);
    wr_word(SKPW, 1'b1, 1'b0);
    wr_word(ENDW, 1'b1, 1'b1);
    wr_word(32'h0300_0002, 1'b0, 1'b0);
    wr_word(32'h0300_0003, 1'b0, 1'b0);
    settle();
    @(negedge rclk);
    rd_expect("R1 data", 1'b1, 32'h0300_0000, 1'b0, 1'b0, 3'b000);
    rd_expect("R1 data", 1'b1, 32'h0300_0001, 1'b0, 1'b0, 3'b000);
    rd_expect("R5 added word", 1'b1, SKPW, 1'b1, 1'b0, 3'b001);
    rd_expect("R5 head kept", 1'b1, SKPW, 1'b1, 1'b0, 3'b000);
    rd_expect("R6 no second add", 1'b1, ENDW, 1'b1, 1'b1, 3'b000);
    rd_expect("R1 data after set", 1'b1, 32'h0300_0002, 1'b0, 1'b0, 3'b000);
    rd_expect("R1 data after set", 1'b1, 32'h0300_0003, 1'b0, 1'b0, 3'b000);
    rd_expect("R7 underflow", 1'b0, '0, 1'b0, 1'b0, 3'b110);
    settle();
  endtask

  task automatic t_overflow();
    int seen = 0;
    for (int i = 0; i < 17; i++) wr_word(32'h0400_0000 + i, 1'b0, 1'b0);
    for (int i = 0; i < 14; i++) begin
      @(negedge rclk);
      if (rd_status == 3'b101) seen++;
    end
    check("R8 overflow reported once", seen, 1);
    for (int i = 0; i < 16; i++)
      rd_expect("R8 stored words intact", 1'b1, 32'h0400_0000 + i, 1'b0, 1'b0, 3'b000);
    rd_expect("R8 extra word dropped", 1'b0, '0, 1'b0, 1'b0, 3'b110);
    settle();
  endtask

  task automatic t_stream();
    int ngrp = 375, exp_n = 0, order_bad = 0, errs = 0, rems = 0;
    int total = 375 * 5;
    bit go = 1'b0;
    rhalf = 4.01;
    fork
      begin
        int n = 0;
        for (int g = 0; g < ngrp; g++) begin
          for (int k = 0; k < 5; k++) begin
            wr_word(32'h5000_0000 + n, 1'b0, 1'b0);
            n++;
            if (n == 8) go = 1'b1;
          end
          wr_word(SKPW, 1'b1, 1'b0);
          wr_word(SKPW, 1'b1, 1'b0);
          wr_word(ENDW, 1'b1, 1'b1);
        end
      end
      begin
        wait (go);
        @(negedge rclk);
        rd_en = 1'b1;
        while (exp_n < total) begin
          @(negedge rclk);
          if (rd_status == 3'b101 || rd_status == 3'b110) errs++;
          if (rd_status == 3'b010) rems++;
          if (rd_valid && !rd_skp) begin
            if (rd_data != 32'h5000_0000 + exp_n) order_bad++;
            exp_n++;
          end
        end
        rd_en = 1'b0;
      end
    join
    check("R9 data order under offset", order_bad, 0);
    check("R9 no full/empty events", errs, 0);
    check("R9 removal happened", rems > 0, 1);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge wclk);
    t_reset();
    t_pass();
    t_delete();
    t_insert();
    t_overflow();
    t_stream();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule